// File: doc/BRIEF.md
# Interrupt Redirection Register File

This block is the software-visible storage of an interrupt router. A 32-bit bus reaches it through two byte offsets only: a select register at offset 0 that names an internal register, and a data window at offset 16 that reads or writes whichever register the select value names. Behind the window sit an identification register, a read-only version register, an arbitration ID register and a redirection table. The table holds one 64-bit entry per interrupt input, and each entry is split into a lower and an upper 32-bit half at two consecutive indices.

Every entry is decoded and driven continuously to a dispatcher, which turns an incoming interrupt into a message. Delivery, end-of-interrupt handling and remote-IRR tracking are done elsewhere. The bus side is served by a four-state machine:
- `S_IDLE` accepts a request (`bus_ready` high).
- `S_RDATA` returns read data.
- `S_WACK` acknowledges a write.
- `S_FAULT` returns an error.

An accepted request moves `S_IDLE` to `S_FAULT` if the offset or the byte enables are illegal. Otherwise it moves to `S_WACK` for a write or to `S_RDATA` for a read. Each of the three response states returns to `S_IDLE` after one cycle.

Top module: `irr_regfile`

## Requirements
- R1: Only accesses with all four byte enables set (`bus_be` = 4'hF) at byte offset 0 or 16 are legal. Any other access gets `rsp_err` = 1 with `rsp_rdata` = 0 and changes no register.
- R2: A request accepted while `bus_ready` is high is answered in the next cycle with `rsp_valid` = 1 for exactly one cycle. `bus_ready` is low during that cycle.
- R3: A legal write to offset 0 stores `bus_wdata[7:0]` as the select index. A read of offset 0 returns that index with bits 31:8 zero.
- R4: Index 0x00 is the ID register. A write keeps only bits 27:24. A read returns the stored ID in bits 27:24 and zero elsewhere.
- R5: Index 0x01 is read-only. A read returns (entries − 1) in bits 23:16 and the version constant in bits 7:0. Writes to it change nothing.
- R6: Index 0x02 is the arbitration ID register. It has the same bits 27:24 layout as the ID register, is independent of it, and resets to the same value as the ID.
- R7: Entry i is reached at index 0x10+2i for its lower half and at index 0x11+2i for its upper half. A write there changes only that half of that entry.
- R8: A write to an entry half stores zero in its reserved bits. Lower-half bits 12, 14 and 31:17 are reserved, so the lower half keeps the mask 0x0001AFFF. Upper-half bits 23:0 are reserved, so the upper half keeps the mask 0xFF000000.
- R9: After reset, every entry reads 0x00010000 (lower) and 0x00000000 (upper), so the mask is set and all other fields are zero. The select index is 0, and both ID and arbitration ID equal `RESET_ID`.
- R10: Indices 0x03 to 0x0F, and indices at or above 0x10+2×entries, read as zero. Writes to them change no register and no entry output.
- R11: The entry outputs decode the lower half as follows: vector = bits 7:0, delivery mode = 10:8, destination mode = 11, polarity = 13, trigger = 15, mask = 16. Destination = upper-half bits 31:24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset inside the block |
| bus_be | input | 4 | Byte enables |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Block can accept a request this cycle |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Response is an error |
| rsp_rdata | output | 32 | Read data of the response |
| ent_vector | output | N_ENT*8 | Vector per entry, entry i in bits 8i+7:8i |
| ent_mode | output | N_ENT*3 | Delivery mode per entry |
| ent_dst_logical | output | N_ENT | Destination mode per entry |
| ent_polarity | output | N_ENT | Polarity per entry |
| ent_level | output | N_ENT | Trigger mode per entry |
| ent_mask | output | N_ENT | Mask per entry |
| ent_dest | output | N_ENT*8 | Destination per entry |

## Verification
The bench builds the block with 24 entries, `RESET_ID` = 3 and version 0x20. These values make the version word distinctive and place the reset ID where writes to either ID register can be told apart from reset. With 24 entries, the last entry (indices 0x3E/0x3F) and the first index past the table (0x40) both fall inside the 8-bit select range. A reference model in the bench covers random select, window and illegal accesses. Directed cases cover reserved-bit clearing, the read-only version register and the holes below 0x10.

// File: rtl/irr_pkg.sv
package irr_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_RDATA = 2'd1,
        S_WACK  = 2'd2,
        S_FAULT = 2'd3
    } bus_state_t;

    localparam logic [31:0] LO_KEEP   = 32'h0001_AFFF;
    localparam logic [31:0] HI_KEEP   = 32'hFF00_0000;
    localparam logic [31:0] LO_RESET  = 32'h0001_0000;
    localparam logic [31:0] HI_RESET  = 32'h0000_0000;

    localparam int IDX_ID     = 'h00;
    localparam int IDX_VER    = 'h01;
    localparam int IDX_ARB    = 'h02;
    localparam int IDX_TABLE  = 'h10;

endpackage

// File: rtl/irr_bus_fsm.sv
module irr_bus_fsm
    import irr_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int SEL_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output logic              bus_ready,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [31:0]       rsp_rdata,
    output logic [SEL_W-1:0]  sel_idx,
    output logic              win_we,
    input  logic [31:0]       win_rdata
);

    localparam logic [ADDR_W-1:0] OFF_SEL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFF_WIN = ADDR_W'(16);

    bus_state_t state_q, state_d;
    logic [31:0] rdata_q;
    logic        accept, off_ok, be_ok, good;

    assign accept = (state_q == S_IDLE) && bus_req;
    assign off_ok = (bus_addr == OFF_SEL) || (bus_addr == OFF_WIN);
    assign be_ok  = (bus_be == 4'hF);
    assign good   = off_ok && be_ok;
    assign win_we = accept && good && bus_we && (bus_addr == OFF_WIN);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (accept) begin
                    if (!good)       state_d = S_FAULT;
                    else if (bus_we) state_d = S_WACK;
                    else             state_d = S_RDATA;
                end
            end
            S_RDATA: state_d = S_IDLE;
            S_WACK:  state_d = S_IDLE;
            S_FAULT: state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        bus_ready = 1'b0;
        rsp_valid = 1'b0;
        rsp_err   = 1'b0;
        rsp_rdata = 32'h0;
        unique case (state_q)
            S_IDLE:  bus_ready = 1'b1;
            S_RDATA: begin
                rsp_valid = 1'b1;
                rsp_rdata = rdata_q;
            end
            S_WACK:  rsp_valid = 1'b1;
            S_FAULT: begin
                rsp_valid = 1'b1;
                rsp_err   = 1'b1;
            end
        endcase
    end

    // select register and captured read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_idx <= '0;
            rdata_q <= 32'h0;
        end else if (accept) begin
            if (good && bus_we && bus_addr == OFF_SEL)
                sel_idx <= bus_wdata[SEL_W-1:0];
            if (good && !bus_we)
                rdata_q <= (bus_addr == OFF_SEL) ? 32'(sel_idx) : win_rdata;
            else
                rdata_q <= 32'h0;
        end
    end

    p_resp_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> rsp_valid);
    p_ready_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !bus_ready);
    p_bad_offset_err_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !off_ok) |=> (rsp_err && rsp_rdata == 32'h0));
    p_sel_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept && bus_we && bus_addr == OFF_SEL) |=> $stable(sel_idx));

endmodule

// File: rtl/irr_index_decode.sv
module irr_index_decode
    import irr_pkg::*;
#(
    parameter int          N_ENT    = 24,
    parameter int          SEL_W    = 8,
    parameter logic [3:0]  RESET_ID = 4'h0,
    parameter logic [7:0]  VERSION  = 8'h11
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [SEL_W-1:0]       sel_idx,
    input  logic                   win_we,
    input  logic [31:0]            win_wdata,
    input  logic [N_ENT-1:0][31:0] lo_all,
    input  logic [N_ENT-1:0][31:0] hi_all,
    output logic [31:0]            win_rdata,
    output logic [N_ENT-1:0]       wr_lo,
    output logic [N_ENT-1:0]       wr_hi
);

    localparam int TBL_END = IDX_TABLE + 2 * N_ENT;
    localparam int ENT_W   = (N_ENT > 1) ? $clog2(N_ENT) : 1;
    localparam logic [7:0] MAX_ENT = 8'(N_ENT - 1);

    logic [3:0] id_q, arb_q;
    logic       in_table, upper;
    logic [ENT_W-1:0] ent;
    int         idx;

    assign idx      = int'(sel_idx);
    assign in_table = (idx >= IDX_TABLE) && (idx < TBL_END);
    assign upper    = sel_idx[0];
    assign ent      = ENT_W'((idx - IDX_TABLE) >> 1);

    always_comb begin
        win_rdata = 32'h0;
        if (idx == IDX_ID)        win_rdata = {4'h0, id_q, 24'h0};
        else if (idx == IDX_VER)  win_rdata = {8'h0, MAX_ENT, 8'h0, VERSION};
        else if (idx == IDX_ARB)  win_rdata = {4'h0, arb_q, 24'h0};
        else if (in_table)        win_rdata = upper ? hi_all[ent] : lo_all[ent];
    end

    always_comb begin
        wr_lo = '0;
        wr_hi = '0;
        if (win_we && in_table) begin
            if (upper) wr_hi[ent] = 1'b1;
            else       wr_lo[ent] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q  <= RESET_ID;
            arb_q <= RESET_ID;
        end else if (win_we) begin
            if (idx == IDX_ID)  id_q  <= win_wdata[27:24];
            if (idx == IDX_ARB) arb_q <= win_wdata[27:24];
        end
    end

    p_one_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_lo, wr_hi}));
    p_id_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(win_we && idx == IDX_ID) |=> $stable(id_q));
    p_arb_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(win_we && idx == IDX_ARB) |=> $stable(arb_q));

endmodule

// File: rtl/irr_redir_entry.sv
module irr_redir_entry
    import irr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic [31:0] wdata,
    output logic [31:0] lo_q,
    output logic [31:0] hi_q,
    output logic [7:0]  vector,
    output logic [2:0]  mode,
    output logic        dst_logical,
    output logic        polarity,
    output logic        level,
    output logic        mask,
    output logic [7:0]  dest
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= LO_RESET;
            hi_q <= HI_RESET;
        end else begin
            if (wr_lo) lo_q <= wdata & LO_KEEP;
            if (wr_hi) hi_q <= wdata & HI_KEEP;
        end
    end

    assign vector      = lo_q[7:0];
    assign mode        = lo_q[10:8];
    assign dst_logical = lo_q[11];
    assign polarity    = lo_q[13];
    assign level       = lo_q[15];
    assign mask        = lo_q[16];
    assign dest        = hi_q[31:24];

    p_lo_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_lo |=> $stable(lo_q));
    p_hi_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hi |=> $stable(hi_q));

endmodule

// File: rtl/irr_regfile.sv
module irr_regfile
    import irr_pkg::*;
#(
    parameter int          N_ENT    = 24,
    parameter int          ADDR_W   = 5,
    parameter logic [3:0]  RESET_ID = 4'h0,
    parameter logic [7:0]  VERSION  = 8'h11
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_req,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [3:0]           bus_be,
    input  logic [31:0]          bus_wdata,
    output logic                 bus_ready,
    output logic                 rsp_valid,
    output logic                 rsp_err,
    output logic [31:0]          rsp_rdata,
    output logic [N_ENT*8-1:0]   ent_vector,
    output logic [N_ENT*3-1:0]   ent_mode,
    output logic [N_ENT-1:0]     ent_dst_logical,
    output logic [N_ENT-1:0]     ent_polarity,
    output logic [N_ENT-1:0]     ent_level,
    output logic [N_ENT-1:0]     ent_mask,
    output logic [N_ENT*8-1:0]   ent_dest
);

    localparam int SEL_W = 8;

    logic [SEL_W-1:0]       sel_idx;
    logic                   win_we;
    logic [31:0]            win_rdata;
    logic [N_ENT-1:0][31:0] lo_all, hi_all;
    logic [N_ENT-1:0]       wr_lo, wr_hi;

    irr_bus_fsm #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .sel_idx(sel_idx), .win_we(win_we), .win_rdata(win_rdata)
    );

    irr_index_decode #(.N_ENT(N_ENT), .SEL_W(SEL_W), .RESET_ID(RESET_ID),
                       .VERSION(VERSION)) u_dec (
        .clk(clk), .rst_n(rst_n), .sel_idx(sel_idx), .win_we(win_we),
        .win_wdata(bus_wdata), .lo_all(lo_all), .hi_all(hi_all),
        .win_rdata(win_rdata), .wr_lo(wr_lo), .wr_hi(wr_hi)
    );

    for (genvar i = 0; i < N_ENT; i++) begin : g_ent
        irr_redir_entry u_ent (
            .clk(clk), .rst_n(rst_n),
            .wr_lo(wr_lo[i]), .wr_hi(wr_hi[i]), .wdata(bus_wdata),
            .lo_q(lo_all[i]), .hi_q(hi_all[i]),
            .vector(ent_vector[i*8 +: 8]),
            .mode(ent_mode[i*3 +: 3]),
            .dst_logical(ent_dst_logical[i]),
            .polarity(ent_polarity[i]),
            .level(ent_level[i]),
            .mask(ent_mask[i]),
            .dest(ent_dest[i*8 +: 8])
        );
    end

endmodule

// File: tb/irr_regfile_bench.sv
module irr_regfile_bench;

    localparam int         N        = 24;
    localparam logic [3:0] RID      = 4'h3;
    localparam logic [7:0] VER      = 8'h20;
    localparam logic [31:0] KLO     = 32'h0001_AFFF;
    localparam logic [31:0] KHI     = 32'hFF00_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_req = 1'b0, bus_we = 1'b0;
    logic [4:0] bus_addr = '0;
    logic [3:0] bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic bus_ready, rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic [N*8-1:0] ent_vector, ent_dest;
    logic [N*3-1:0] ent_mode;
    logic [N-1:0] ent_dst_logical, ent_polarity, ent_level, ent_mask;

    always #10 clk = ~clk;

    irr_regfile #(.N_ENT(N), .ADDR_W(5), .RESET_ID(RID), .VERSION(VER)) u_irr_regfile (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_ready(bus_ready), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata), .ent_vector(ent_vector), .ent_mode(ent_mode),
        .ent_dst_logical(ent_dst_logical), .ent_polarity(ent_polarity),
        .ent_level(ent_level), .ent_mask(ent_mask), .ent_dest(ent_dest)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    logic [7:0]  m_sel;
    logic [3:0]  m_id, m_arb;
    logic [31:0] m_lo [N];
    logic [31:0] m_hi [N];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(input logic [7:0] idx);
        int i = int'(idx);
        if (i == 0) return {4'h0, m_id, 24'h0};
        if (i == 1) return {8'h0, 8'(N - 1), 8'h0, VER};
        if (i == 2) return {4'h0, m_arb, 24'h0};
        if (i >= 16 && i < 16 + 2 * N) return idx[0] ? m_hi[(i - 16) / 2] : m_lo[(i - 16) / 2];
        return 32'h0;
    endfunction

    function automatic void model_wr(input logic [7:0] idx, input logic [31:0] wd);
        int i = int'(idx);
        if (i == 0) m_id = wd[27:24];
        else if (i == 2) m_arb = wd[27:24];
        else if (i >= 16 && i < 16 + 2 * N) begin
            if (idx[0]) m_hi[(i - 16) / 2] = wd & KHI;
            else        m_lo[(i - 16) / 2] = wd & KLO;
        end
    endfunction

    // R11 field layout of every entry output
    task automatic chk_entries(input string req);
        for (int e = 0; e < N; e++) begin
            logic [31:0] act, exp;
            act = {ent_dest[e*8 +: 8], 2'b0, ent_mask[e], ent_level[e], 1'b0,
                   ent_polarity[e], 1'b0, ent_dst_logical[e], ent_mode[e*3 +: 3],
                   ent_vector[e*8 +: 8]};
            exp = {m_hi[e][31:24], 2'b0, m_lo[e][16], m_lo[e][15], 1'b0,
                   m_lo[e][13], 1'b0, m_lo[e][11], m_lo[e][10:8], m_lo[e][7:0]};
            chk(req, act, exp);
        end
    endtask

    // one bus access, starting and ending at a falling edge
    task automatic op(input string req, input bit we, input logic [4:0] a,
                      input logic [3:0] be, input logic [31:0] wd);
        bit bad;
        logic [31:0] exp;
        bad = !((a == 5'd0) || (a == 5'd16)) || (be != 4'hF);
        exp = 32'h0;
        if (!bad && !we) exp = (a == 5'd0) ? {24'h0, m_sel} : exp_rd(m_sel);
        chk({req, " R2 ready"}, {31'h0, bus_ready}, 32'h1);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_be = be; bus_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        bus_req = 1'b0;
        chk({req, " R2 valid"}, {30'h0, rsp_valid, bus_ready}, 32'h2);
        chk({req, " R1 err"}, {31'h0, rsp_err}, {31'h0, bad});
        chk({req, " rdata"}, rsp_rdata, exp);
        if (!bad && we) begin
            if (a == 5'd0) m_sel = wd[7:0];
            else model_wr(m_sel, wd);
        end
        @(negedge clk);
        chk({req, " R2 single"}, {31'h0, rsp_valid}, 32'h0);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        m_sel = 8'h0; m_id = RID; m_arb = RID;
        for (int e = 0; e < N; e++) begin m_lo[e] = 32'h0001_0000; m_hi[e] = 32'h0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 reset state
        chk("R9 mask", 32'(ent_mask), 32'(24'hFFFFFF));
        chk_entries("R9 R11 reset entries");
        chk("R9 idle", {30'h0, rsp_valid, bus_ready}, 32'h1);
        op("R3 R9 sel read", 1'b0, 5'd0, 4'hF, 32'h0);
        op("R4 R9 id read", 1'b0, 5'd16, 4'hF, 32'h0);
        op("R5 sel ver", 1'b1, 5'd0, 4'hF, 32'hFFFF_FF01);
        op("R3 sel trunc", 1'b0, 5'd0, 4'hF, 32'h0);
        op("R5 ver read", 1'b0, 5'd16, 4'hF, 32'h0);
        op("R5 ver write", 1'b1, 5'd16, 4'hF, 32'hFFFF_FFFF);
        op("R5 ver reread", 1'b0, 5'd16, 4'hF, 32'h0);
        op("R6 sel arb", 1'b1, 5'd0, 4'hF, 32'h2);
        op("R6 R9 arb reset", 1'b0, 5'd16, 4'hF, 32'h0);
        op("R6 sel id", 1'b1, 5'd0, 4'hF, 32'h0);
        op("R4 id write", 1'b1, 5'd16, 4'hF, 32'hFFFF_FFFF);
        op("R4 id read", 1'b0, 5'd16, 4'hF, 32'h0);
        op("R6 sel arb2", 1'b1, 5'd0, 4'hF, 32'h2);
        op("R6 arb indep", 1'b0, 5'd16, 4'hF, 32'h0);
        // R8 reserved bits, R7 mapping at entry 0 and last entry
        op("R7 sel e0lo", 1'b1, 5'd0, 4'hF, 32'h10);
        op("R8 e0lo wr", 1'b1, 5'd16, 4'hF, 32'hFFFF_FFFF);
        op("R8 e0lo rd", 1'b0, 5'd16, 4'hF, 32'h0);
        chk("R8 lo keep", m_lo[0], 32'h0001_AFFF);
        op("R7 sel e23hi", 1'b1, 5'd0, 4'hF, 32'h3F);
        op("R8 e23hi wr", 1'b1, 5'd16, 4'hF, 32'hFFFF_FFFF);
        op("R8 e23hi rd", 1'b0, 5'd16, 4'hF, 32'h0);
        chk_entries("R7 R11 after edges");
        // R10 holes
        op("R10 sel past", 1'b1, 5'd0, 4'hF, 32'h40);
        op("R10 past wr", 1'b1, 5'd16, 4'hF, 32'hFFFF_FFFF);
        op("R10 past rd", 1'b0, 5'd16, 4'hF, 32'h0);
        op("R10 sel hole", 1'b1, 5'd0, 4'hF, 32'h7);
        op("R10 hole wr", 1'b1, 5'd16, 4'hF, 32'hFFFF_FFFF);
        op("R10 hole rd", 1'b0, 5'd16, 4'hF, 32'h0);
        chk_entries("R10 entries untouched");
        // R1 illegal accesses
        op("R1 bad off", 1'b1, 5'd4, 4'hF, 32'h12);
        op("R1 bad be", 1'b1, 5'd0, 4'h3, 32'h12);
        op("R1 bad be win", 1'b1, 5'd16, 4'h1, 32'hFFFF_FFFF);
        op("R1 sel kept", 1'b0, 5'd0, 4'hF, 32'h0);
        chk_entries("R1 entries untouched");

        for (int k = 0; k < 900; k++) begin
            int r;
            r = int'($urandom % 10);
            if (r < 3) begin
                logic [31:0] s;
                s = ($urandom % 4 == 0) ? ($urandom % 4) : ($urandom % 8'h48);
                op("R3 rnd sel", 1'b1, 5'd0, 4'hF, s);
            end else if (r < 6) begin
                op("R7 R8 rnd wr", 1'b1, 5'd16, 4'hF, $urandom);
                chk_entries("R11 rnd entries");
            end else if (r < 9) begin
                op("R7 rnd rd", 1'b0, ($urandom % 3 == 0) ? 5'd0 : 5'd16, 4'hF, 32'h0);
            end else begin
                logic [4:0] a;
                a = 5'($urandom);
                if (a == 5'd0 || a == 5'd16) op("R1 rnd be", 1'b1, a, 4'($urandom % 15), $urandom);
                else op("R1 rnd off", $urandom % 2 == 1, a, 4'hF, $urandom);
            end
        end
        chk_entries("R11 final");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule